// File: doc/BRIEF.md
# Masked-Write GPIO Controller

This block is a 32-pin general-purpose I/O controller reached over a plain 32-bit register bus: a word address, a write strobe, write data and combinational read data. Software drives the pins through an output value register and an output-enable register. Each one can be written as a whole word. Each one can also be written per 16-bit half through masked registers, which change only the bits selected by a mask. This lets independent software agents own different pins without a read-modify-write race.

The input pins pass through a two-flop synchronizer. Each pin has an optional 16-cycle glitch filter. The block reports the resulting pin values and watches every pin for four conditions: rising edge, falling edge, level high and level low. Each condition is enabled per pin. An enabled condition sets a sticky per-pin state bit, and software clears it by writing ones. A test register lets software raise state bits directly. The interrupt line is high while any state bit is set whose enable bit is also set.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset every register is zero: pins_o, pins_oe_o, irq_o, the state, all enables and the filter enables.
- R2: A write to 0x10 replaces the whole output value. A write to 0x1C replaces the whole output enable. Bit n drives pin n, and both registers read back at their own addresses.
- R3: A write to 0x14 (pins 0-15) or 0x18 (pins 16-31) changes an output bit k only where mask bit k+16 of the write data is 1. That bit takes write-data bit k. When read, these addresses return the current 16 bits of their half in bits 15:0, with bits 31:16 as zero.
- R4: The masked output-enable writes at 0x20 (pins 0-15) and 0x24 (pins 16-31) follow the same rule as R3. They change the same state that 0x1C reads back.
- R5: The interrupt state at 0x00 is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: Writing 1 to bit n of 0x08 sets state bit n on that clock edge. If a hardware condition and a software clear hit the same bit in the same cycle, the bit stays set. Address 0x08 reads as zero.
- R7: Address 0x0C reads the pin values two clock edges after they change at the pins. Writes to 0x0C have no effect.
- R8: The per-pin enables are rising at 0x28, falling at 0x2C, level high at 0x30 and level low at 0x34. An edge compares this cycle's pin value with last cycle's. An enabled, true condition sets the pin's state bit on the next edge.
- R9: irq_o is high exactly when some state bit is set and its enable bit at 0x04 is also set.
- R10: When filter bit n at 0x38 is set, the reported value of pin n changes only after the synchronized input has differed from it for 16 consecutive cycles. Shorter pulses are not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pins_i | input | 32 | Raw pin inputs |
| pins_o | output | 32 | Output pin values |
| pins_oe_o | output | 32 | Output pin enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The masked writes are tried with a partial mask, a full-half mask and an all-zero mask. This shows the difference between merging bits, replacing a half and ignoring the write, and it checks that the lower and upper halves never disturb each other. The input side is driven with steady levels, single edges in each direction and short and long pulses on a filtered pin. These separate the edge conditions from the level conditions and a rejected glitch from an accepted change. Clears are applied to edge-triggered bits and to level bits that are still active, which shows a plain clear apart from the case where the set wins, and injected test bits confirm the interrupt gating by the enable mask.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned AW   = 6;
  localparam int unsigned HALF = 16;

  localparam logic [AW-1:0] A_STATE   = 6'h00;
  localparam logic [AW-1:0] A_IEN     = 6'h04;
  localparam logic [AW-1:0] A_TEST    = 6'h08;
  localparam logic [AW-1:0] A_DIN     = 6'h0C;
  localparam logic [AW-1:0] A_DOUT    = 6'h10;
  localparam logic [AW-1:0] A_MOUT_LO = 6'h14;
  localparam logic [AW-1:0] A_MOUT_HI = 6'h18;
  localparam logic [AW-1:0] A_DOE     = 6'h1C;
  localparam logic [AW-1:0] A_MOE_LO  = 6'h20;
  localparam logic [AW-1:0] A_MOE_HI  = 6'h24;
  localparam logic [AW-1:0] A_RISE    = 6'h28;
  localparam logic [AW-1:0] A_FALL    = 6'h2C;
  localparam logic [AW-1:0] A_HIGH    = 6'h30;
  localparam logic [AW-1:0] A_LOW     = 6'h34;
  localparam logic [AW-1:0] A_FILT    = 6'h38;

  // plain per-pin config registers
  typedef enum int unsigned {
    CFG_IEN  = 0,
    CFG_RISE = 1,
    CFG_FALL = 2,
    CFG_HIGH = 3,
    CFG_LOW  = 4,
    CFG_FILT = 5
  } cfg_idx_e;
  localparam int unsigned NCFG = 6;

  function automatic logic [AW-1:0] cfg_addr(int unsigned idx);
    case (idx)
      CFG_IEN:  return A_IEN;
      CFG_RISE: return A_RISE;
      CFG_FALL: return A_FALL;
      CFG_HIGH: return A_HIGH;
      CFG_LOW:  return A_LOW;
      default:  return A_FILT;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPIN     = 32,
  parameter int unsigned FILT_LEN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] filt_en_i,
  output logic [NPIN-1:0] data_o
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [NPIN-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pins_i;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // count consecutive cycles the sample disagrees with the filtered value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else if (sync2_q[i] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        filt_q <= sync2_q[i];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign data_o[i] = filt_en_i[i] ? filt_q : sync2_q[i];
  end
endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg
  import gpio_pkg::*;
#(
  parameter int unsigned   NPIN   = 32,
  parameter logic [AW-1:0] A_FULL = A_DOUT,
  parameter logic [AW-1:0] A_LO   = A_MOUT_LO,
  parameter logic [AW-1:0] A_HI   = A_MOUT_HI
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] q_o
);
  localparam int unsigned NHALF = NPIN / HALF;

  logic [NPIN-1:0] q_q, q_d;
  logic [HALF-1:0] wr_data, wr_mask;

  assign wr_data = wdata_i[HALF-1:0];
  assign wr_mask = wdata_i[2*HALF-1:HALF];

  always_comb begin
    q_d = q_q;
    if (we_i && addr_i == A_FULL) q_d = wdata_i;
    for (int h = 0; h < NHALF; h++) begin
      if (we_i && addr_i == ((h == 0) ? A_LO : A_HI))
        q_d[h*HALF +: HALF] = (q_q[h*HALF +: HALF] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] data_i,
  input  logic [NPIN-1:0] rise_en_i,
  input  logic [NPIN-1:0] fall_en_i,
  input  logic [NPIN-1:0] high_en_i,
  input  logic [NPIN-1:0] low_en_i,
  input  logic [NPIN-1:0] clr_i,
  input  logic [NPIN-1:0] test_i,
  output logic [NPIN-1:0] state_o
);
  logic [NPIN-1:0] prev_q, state_q, hw_set;

  assign hw_set = (rise_en_i &  data_i & ~prev_q)
                | (fall_en_i & ~data_i &  prev_q)
                | (high_en_i &  data_i)
                | (low_en_i  & ~data_i);

  // sets applied after the clear so they win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      state_q <= '0;
    end else begin
      prev_q  <= data_i;
      state_q <= (state_q & ~clr_i) | hw_set | test_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN     = 32,
  parameter int unsigned FILT_LEN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] pins_i,
  output logic [NPIN-1:0] pins_o,
  output logic [NPIN-1:0] pins_oe_o,
  output logic            irq_o
);
  logic [NPIN-1:0] cfg_q [NCFG];
  logic [NPIN-1:0] din, state_q, clr, tst;

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_q[c] <= '0;
      else if (we_i && addr_i == cfg_addr(c))   cfg_q[c] <= wdata_i;
    end
  end

  gpio_masked_reg #(.NPIN(NPIN), .A_FULL(A_DOUT), .A_LO(A_MOUT_LO), .A_HI(A_MOUT_HI)) u_out (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(pins_o)
  );

  gpio_masked_reg #(.NPIN(NPIN), .A_FULL(A_DOE), .A_LO(A_MOE_LO), .A_HI(A_MOE_HI)) u_oe (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(pins_oe_o)
  );

  gpio_in_sync #(.NPIN(NPIN), .FILT_LEN(FILT_LEN)) u_in (
    .clk_i, .rst_ni, .pins_i, .filt_en_i(cfg_q[CFG_FILT]), .data_o(din)
  );

  assign clr = (we_i && addr_i == A_STATE) ? wdata_i : '0;
  assign tst = (we_i && addr_i == A_TEST)  ? wdata_i : '0;

  gpio_irq_ctrl #(.NPIN(NPIN)) u_irq (
    .clk_i, .rst_ni,
    .data_i(din),
    .rise_en_i(cfg_q[CFG_RISE]),
    .fall_en_i(cfg_q[CFG_FALL]),
    .high_en_i(cfg_q[CFG_HIGH]),
    .low_en_i(cfg_q[CFG_LOW]),
    .clr_i(clr),
    .test_i(tst),
    .state_o(state_q)
  );

  assign irq_o = |(state_q & cfg_q[CFG_IEN]);

  always_comb begin
    case (addr_i)
      A_STATE:   rdata_o = state_q;
      A_IEN:     rdata_o = cfg_q[CFG_IEN];
      A_DIN:     rdata_o = din;
      A_DOUT:    rdata_o = pins_o;
      A_MOUT_LO: rdata_o = {{HALF{1'b0}}, pins_o[HALF-1:0]};
      A_MOUT_HI: rdata_o = {{HALF{1'b0}}, pins_o[2*HALF-1:HALF]};
      A_DOE:     rdata_o = pins_oe_o;
      A_MOE_LO:  rdata_o = {{HALF{1'b0}}, pins_oe_o[HALF-1:0]};
      A_MOE_HI:  rdata_o = {{HALF{1'b0}}, pins_oe_o[2*HALF-1:HALF]};
      A_RISE:    rdata_o = cfg_q[CFG_RISE];
      A_FALL:    rdata_o = cfg_q[CFG_FALL];
      A_HIGH:    rdata_o = cfg_q[CFG_HIGH];
      A_LOW:     rdata_o = cfg_q[CFG_LOW];
      A_FILT:    rdata_o = cfg_q[CFG_FILT];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_ctrl_chk.sv
module gpio_mask_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [NPIN-1:0] wdata_i,
  input logic [NPIN-1:0] pins_o,
  input logic [NPIN-1:0] pins_oe_o,
  input logic            irq_o,
  input logic [NPIN-1:0] intr_state,
  input logic [NPIN-1:0] intr_en
);
  p_direct_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DOUT) |=> pins_o == $past(wdata_i));

  p_zero_mask_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_MOUT_LO || addr_i == A_MOUT_HI) && wdata_i[NPIN-1:HALF] == '0)
      |=> $stable(pins_o));

  p_zero_mask_keeps_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_MOE_LO || addr_i == A_MOE_HI) && wdata_i[NPIN-1:HALF] == '0)
      |=> $stable(pins_oe_o));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_STATE) |=> (($past(intr_state) & ~intr_state) == '0));

  p_test_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_TEST) |=> ((intr_state & $past(wdata_i)) == $past(wdata_i)));

  p_din_write_inert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIN) |=> ($stable(pins_o) && $stable(pins_oe_o)));

  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_en == '0) |-> !irq_o);
endmodule

bind gpio_mask_ctrl gpio_mask_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .pins_o(pins_o), .pins_oe_o(pins_oe_o), .irq_o(irq_o),
  .intr_state(state_q), .intr_en(cfg_q[gpio_pkg::CFG_IEN])
);

// File: tb/gpio_mask_ctrl_bench.sv
module gpio_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pins = '0, pout, poe;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  gpio_mask_ctrl u_gpio_mask_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pins_i(pins), .pins_o(pout), .pins_oe_o(poe), .irq_o(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_s1, m_s2, m_prev, m_filt, m_out, m_oe, m_ie, m_state;
  logic [31:0] m_rise, m_fall, m_hi, m_lo, m_fen;
  int          m_cnt [32];

  function automatic logic [31:0] m_din();
    return (m_fen & m_filt) | (~m_fen & m_s2);
  endfunction

  function automatic logic [31:0] merge(logic [15:0] old, logic [31:0] w);
    return {16'h0, (old & ~w[31:16]) | (w[15:0] & w[31:16])};
  endfunction

  function automatic logic [31:0] m_rd(logic [5:0] a);
    case (a)
      6'h00: return m_state;  6'h04: return m_ie;   6'h0C: return m_din();
      6'h10: return m_out;    6'h14: return {16'h0, m_out[15:0]};
      6'h18: return {16'h0, m_out[31:16]};          6'h1C: return m_oe;
      6'h20: return {16'h0, m_oe[15:0]};            6'h24: return {16'h0, m_oe[31:16]};
      6'h28: return m_rise;   6'h2C: return m_fall; 6'h30: return m_hi;
      6'h34: return m_lo;     6'h38: return m_fen;  default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] a);
    case (a)
      6'h00: return "R5";  6'h08: return "R6";  6'h0C: return "R7";
      6'h10, 6'h14, 6'h18: return "R3";
      6'h1C, 6'h20, 6'h24: return "R4";
      6'h38: return "R10";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_filt = 0; m_out = 0; m_oe = 0; m_ie = 0;
      m_state = 0; m_rise = 0; m_fall = 0; m_hi = 0; m_lo = 0; m_fen = 0;
      for (int i = 0; i < 32; i++) m_cnt[i] = 0;
    end else begin
      logic [31:0] d, hw, clr, tst;
      d   = m_din();
      hw  = (m_rise & d & ~m_prev) | (m_fall & ~d & m_prev) | (m_hi & d) | (m_lo & ~d);
      clr = (we && addr == 6'h00) ? wdata : 0;
      tst = (we && addr == 6'h08) ? wdata : 0;
      m_state = (m_state & ~clr) | hw | tst;
      m_prev  = d;
      for (int i = 0; i < 32; i++) begin
        if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == 15) begin m_cnt[i] = 0; m_filt[i] = m_s2[i]; end
        else m_cnt[i]++;
      end
      m_s2 = m_s1; m_s1 = pins;
      if (we) case (addr)
        6'h04: m_ie = wdata;   6'h10: m_out = wdata;  6'h1C: m_oe = wdata;
        6'h14: m_out[15:0]  = merge(m_out[15:0],  wdata)[15:0];
        6'h18: m_out[31:16] = merge(m_out[31:16], wdata)[15:0];
        6'h20: m_oe[15:0]   = merge(m_oe[15:0],   wdata)[15:0];
        6'h24: m_oe[31:16]  = merge(m_oe[31:16],  wdata)[15:0];
        6'h28: m_rise = wdata; 6'h2C: m_fall = wdata; 6'h30: m_hi = wdata;
        6'h34: m_lo = wdata;   6'h38: m_fen = wdata;
        default: ;
      endcase
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) if (rst_n) begin
    check("R2", pout, m_out);
    check("R4", poe, m_oe);
    check("R9", {31'h0, irq}, {31'h0, |(m_state & m_ie)});
    check(tag_of(addr), rdata, m_rd(addr));
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(posedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    check("R1", pout, 32'h0);
    check("R1", poe, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);
    rd(6'h00, v); check("R1", v, 32'h0);

    // R2 direct writes
    wr(6'h10, 32'hA5A5_0F0F); rd(6'h10, v); check("R2", v, 32'hA5A5_0F0F);
    wr(6'h1C, 32'hFFFF_0000); rd(6'h1C, v); check("R2", v, 32'hFFFF_0000);

    // R3 masked output: partial, full-half, zero mask
    wr(6'h14, 32'h00F0_1234); check("R3", pout, 32'hA5A5_0F3F);
    wr(6'h18, 32'hFF00_5A00); check("R3", pout, 32'h5AA5_0F3F);
    rd(6'h18, v); check("R3", v, 32'h0000_5AA5);
    wr(6'h14, 32'h0000_FFFF); check("R3", pout, 32'h5AA5_0F3F);
    wr(6'h14, 32'hFFFF_C3C3); check("R3", pout, 32'h5AA5_C3C3);

    // R4 masked output enable
    wr(6'h20, 32'h000F_0005); wr(6'h24, 32'h8000_0000);
    rd(6'h1C, v); check("R4", v, 32'h7FFF_0005);
    rd(6'h20, v); check("R4", v, 32'h0000_0005);

    // R8 conditions: rise pin3, fall pin5, high pin7, low pin9
    wr(6'h04, 32'h0010_02A8);
    wr(6'h28, 32'h0000_0008); wr(6'h2C, 32'h0000_0020);
    wr(6'h30, 32'h0000_0080); wr(6'h34, 32'h0000_0200);
    idle(2); wr(6'h00, 32'hFFFF_FFFF); idle(2);
    rd(6'h00, v); check("R8", v, 32'h0000_0200);
    pins = 32'h0000_0028; idle(5);
    rd(6'h00, v); check("R8", v, 32'h0000_0208);
    pins = 32'h0000_0008; idle(5);
    rd(6'h00, v); check("R8", v, 32'h0000_0228);
    pins = 32'h0000_0088; idle(5);
    rd(6'h00, v); check("R8", v, 32'h0000_02A8);
    check("R9", {31'h0, irq}, 32'h1);

    // R5 write-zero no effect, write-one clears
    wr(6'h00, 32'h0); rd(6'h00, v); check("R5", v, 32'h0000_02A8);
    wr(6'h00, 32'h0000_0028); rd(6'h00, v); check("R5", v, 32'h0000_0280);

    // R6 clear of an active level bit loses to the set; test injection
    wr(6'h00, 32'h0000_0080); rd(6'h00, v); check("R6", v, 32'h0000_0280);
    wr(6'h08, 32'h0010_0000); rd(6'h00, v); check("R6", v, 32'h0010_0280);
    rd(6'h08, v); check("R6", v, 32'h0);

    // R9 gating by enables
    wr(6'h04, 32'h0);
    idle(1); check("R9", {31'h0, irq}, 32'h0);
    wr(6'h04, 32'h0010_0000);
    idle(1); check("R9", {31'h0, irq}, 32'h1);
    wr(6'h00, 32'h0010_0000);
    idle(1); check("R9", {31'h0, irq}, 32'h0);

    // R7 input register ignores writes
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); check("R7", v, 32'h0000_0088);
    pins = 32'h8000_0088; idle(1); rd(6'h0C, v); check("R7", v, 32'h8000_0088);

    // R10 filter on pin 12: short pulse rejected, long level accepted
    wr(6'h38, 32'h0000_1000);
    pins[12] = 1'b1; idle(5); pins[12] = 1'b0; idle(20);
    rd(6'h0C, v); check("R10", {31'h0, v[12]}, 32'h0);
    pins[12] = 1'b1; idle(10);
    rd(6'h0C, v); check("R10", {31'h0, v[12]}, 32'h0);
    idle(15);
    rd(6'h0C, v); check("R10", {31'h0, v[12]}, 32'h1);

    idle(3);
    finish_run();
  end
endmodule